// File: doc/BRIEF.md
# MDIO Management Master

This block lets software run one Clause 22 management frame at a time on an MDC/MDIO pair. It sits on a simple register bus that decodes two 32-bit words. The command word at address 0 accepts a launch request together with the frame fields. The timing and status word at address 4 holds the clock divider, the drive-edge select, the read sample delay, an idle flag and the 16 bits returned by the last read.

Once a launch is accepted, the block builds the whole 64-bit frame and shifts it out, most significant bit first, on an MDC that it derives from the system clock. On a read it releases the data line at the turnaround and samples 16 reply bits. Software launches a frame and polls the busy bit in the command word until it clears. For a read it then polls the idle flag before it uses the returned data. The idle flag can trail the busy bit because the last sample is delayed.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the busy bit (command word bit 31) is 0, the idle flag (status word bit 16) is 1, MDC is low and the MDIO output enable is low. The status word reads 32'h0001_0000.
- R2: A bus write to address 0 with bit 31 = 1 and bit 28 = 1 is accepted when the idle flag is 1. From the following cycle the busy bit reads 1 for exactly 128*H system cycles, where H is the MDC half-period.
- R3: H equals status bits 31:24, and a value of 0 counts as 1. MDC is low when the frame starts, toggles every H cycles for 64 periods, and is low whenever the engine is not busy.
- R4: The frame is sent MSB first in this order: 32 ones, then 0 and 1, then the two opcode bits 27:26, the PHY address bits 25:21 and the register address bits 20:16. When the opcode is not 2'b10, the turnaround 1,0 and the 16 data bits 15:0 follow.
- R5: With status bit 23 = 0, frame bit j is presented from the j-th MDC fall (half-slot 2j). With bit 23 = 1, each bit j >= 1 is presented half a period earlier, from half-slot 2j-1, and bit 63 is held to the end.
- R6: For opcode 2'b10 (read), the output enable is low from frame bit 46 to the end of the frame. Whenever the output enable is low, the MDIO output level is 1.
- R7: For a read, each of bits 48..63 is sampled from mdioIn at the clock edge 1+D cycles after the edge on which MDC rose in that bit, where D = min(status bits 22:20, 2H-2). The 16 samples form status bits 15:0, first sample in bit 15.
- R8: The idle flag is 0 from acceptance until busy has cleared and the last read sample has been taken. After that, status bits 15:0 hold the read result.
- R9: A command-word write made while the idle flag is 0 is ignored. It does not change the frame in progress or the stored command fields.
- R10: A command-word write with bit 28 = 0 (a Clause 45 request) or with bit 31 = 0 launches nothing and leaves the stored fields unchanged.
- R11: The command word reads {busy, 2'b00, 1 once any frame has been accepted, the 28 stored bits 27:0}. The status word reads {H field, edge bit, delay field, 3'b000, idle, read data}. Status bits 31:20 are writable at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register byte address (0 command, 4 status) |
| regWdata | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO output level |
| mdioOe | output | 1 | MDIO output enable (low means released, pulled up) |
| mdioIn | input | 1 | MDIO input level |

## Verification
The embedded assertions check on every cycle that MDC stays low while idle, that a frame ends only after its last half-slot, and that the bit index never skips or steps back during a frame. They also check that the preamble bits go out as ones, that a sample strobe only occurs on read frames, and that two samples are never taken on adjacent cycles. Only the bench scenarios can show the rest. That covers the full bit sequence of each frame under both edge settings and several divider values, and the clamping of the sample delay, which the bench detects through the value it reads back. It also covers the lag of the idle flag behind the busy bit, and the rejection of mid-frame, Clause 45 and non-launch writes seen through register readback.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TURN_IDX  = PRE_LEN + 14;
  localparam int DATA_IDX  = PRE_LEN + 16;
  localparam int CMD_W     = 28;
  localparam int THR_W     = 8;
  localparam int LAT_W     = 3;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  phy;
    logic [4:0]  regAd;
    logic [15:0] wdata;
  } mdio_cmd_t;

  typedef struct packed {
    logic             load;
    logic             busy;
    logic [IDX_W-1:0] bitIdx;
    logic             capture;
  } mdio_strobe_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int TW      = THR_W,
  parameter int LW      = LAT_W,
  parameter int FRAME_N = FRAME_LEN
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          cfgWrEn,
  input  logic [TW-1:0] cfgThrIn,
  input  logic          cfgEdgeIn,
  input  logic [LW-1:0] cfgLatIn,
  input  logic          cmdIsRead,
  output logic [TW-1:0] cfgThr,
  output logic          cfgEdge,
  output logic [LW-1:0] cfgLat,
  output logic          busy,
  output logic          idle,
  output logic          mdc,
  output mdio_strobe_t  strobe
);
  localparam int HALF_N  = 2 * FRAME_N;
  localparam int HW      = $clog2(HALF_N);
  localparam int IW      = $clog2(FRAME_N);
  localparam int DW      = TW + 1;
  localparam int DSTART  = FRAME_N - 16;

  logic [TW-1:0] divCnt;
  logic [HW-1:0] halfCnt;
  logic          pend;
  logic [LW-1:0] dly;

  logic [TW-1:0] halfLen;
  logic [DW-1:0] maxDly;
  logic [LW-1:0] latEff;
  logic          tick, accept, riseInData, lastHalf;
  logic [IW-1:0] bitNow, leadIdx;
  logic [HW-1:0] leadFull;

  always_comb begin
    halfLen = (cfgThr == '0) ? TW'(1) : cfgThr;
    maxDly  = {halfLen, 1'b0} - DW'(2);
    latEff  = (DW'(cfgLat) > maxDly) ? maxDly[LW-1:0] : cfgLat;
  end

  assign idle       = !busy && !pend;
  assign accept     = startReq && idle;
  assign tick       = busy && (divCnt >= halfLen - TW'(1));
  assign lastHalf   = (halfCnt == HW'(HALF_N - 1));
  assign bitNow     = halfCnt[HW-1:1];
  assign riseInData = tick && !halfCnt[0] && cmdIsRead && (bitNow >= IW'(DSTART));
  assign leadFull   = {1'b0, halfCnt[HW-1:1]} + {{(HW-1){1'b0}}, halfCnt[0]};
  assign leadIdx    = (leadFull >= HW'(FRAME_N)) ? IW'(FRAME_N - 1) : leadFull[IW-1:0];
  assign mdc        = halfCnt[0];

  always_comb begin
    strobe.load    = accept;
    strobe.busy    = busy;
    strobe.bitIdx  = cfgEdge ? leadIdx : bitNow;
    strobe.capture = pend && (dly == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgThr  <= '0;
      cfgEdge <= 1'b0;
      cfgLat  <= '0;
      busy    <= 1'b0;
      divCnt  <= '0;
      halfCnt <= '0;
      pend    <= 1'b0;
      dly     <= '0;
    end else begin
      if (cfgWrEn) begin
        cfgThr  <= cfgThrIn;
        cfgEdge <= cfgEdgeIn;
        cfgLat  <= cfgLatIn;
      end
      if (accept) begin
        busy    <= 1'b1;
        divCnt  <= '0;
        halfCnt <= '0;
      end else if (busy) begin
        if (tick) begin
          divCnt <= '0;
          if (lastHalf) begin
            busy    <= 1'b0;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + HW'(1);
          end
        end else begin
          divCnt <= divCnt + TW'(1);
        end
      end
      if (riseInData) begin
        pend <= 1'b1;
        dly  <= latEff;
      end else if (pend) begin
        if (dly == '0) pend <= 1'b0;
        else           dly  <= dly - LW'(1);
      end
    end
  end

  // R3
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(halfCnt) == HW'(HALF_N - 1)));

  // R7
  capture_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture);
endmodule

// File: rtl/mdio_mgmt_dp.sv
module mdio_mgmt_dp
  import mdio_mgmt_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mdio_strobe_t strobe,
  input  mdio_cmd_t    cmdIn,
  input  logic         mdioIn,
  output mdio_cmd_t    cmdQ,
  output logic         stSeen,
  output logic         isRead,
  output logic [15:0]  rdData,
  output logic         mdioOut,
  output logic         mdioOe
);
  logic [FRAME_LEN-1:0] frame;

  assign isRead = (cmdQ.op == OP_READ);

  always_comb begin
    frame   = {{PRE_LEN{1'b1}}, 2'b01, cmdQ.op, cmdQ.phy, cmdQ.regAd,
               (isRead ? 2'b11 : 2'b10), cmdQ.wdata};
    mdioOe  = strobe.busy && !(isRead && (strobe.bitIdx >= IDX_W'(TURN_IDX)));
    mdioOut = mdioOe ? frame[IDX_W'(FRAME_LEN - 1) - strobe.bitIdx] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ   <= '0;
      stSeen <= 1'b0;
      rdData <= '0;
    end else begin
      if (strobe.load) begin
        cmdQ   <= cmdIn;
        stSeen <= 1'b1;
      end
      if (strobe.capture) rdData <= {rdData[14:0], mdioIn};
    end
  end

  // R4
  preamble_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && (strobe.bitIdx < IDX_W'(PRE_LEN))) |-> mdioOut);

  // R7
  capture_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> isRead);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.busy && $past(strobe.busy)) |->
      ((strobe.bitIdx == $past(strobe.bitIdx)) ||
       (strobe.bitIdx == $past(strobe.bitIdx) + IDX_W'(1))));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  logic            cmdHit, statHit, startReq, cfgWrEn;
  logic [THR_W-1:0] cfgThr;
  logic            cfgEdge;
  logic [LAT_W-1:0] cfgLat;
  logic            busy, idle, isRead, stSeen;
  logic [15:0]     rdData;
  mdio_cmd_t       cmdQ;
  mdio_strobe_t    strobe;
  logic            unusedWdata;

  assign cmdHit      = (regAddr == ADDR_W'(0));
  assign statHit     = (regAddr == ADDR_W'(4));
  assign startReq    = regWrEn && cmdHit && regWdata[31] && regWdata[28];
  assign cfgWrEn     = regWrEn && statHit;
  assign unusedWdata = ^regWdata[30:29];

  mdio_mgmt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cfgWrEn   (cfgWrEn),
    .cfgThrIn  (regWdata[31:24]),
    .cfgEdgeIn (regWdata[23]),
    .cfgLatIn  (regWdata[22:20]),
    .cmdIsRead (isRead),
    .cfgThr    (cfgThr),
    .cfgEdge   (cfgEdge),
    .cfgLat    (cfgLat),
    .busy      (busy),
    .idle      (idle),
    .mdc       (mdc),
    .strobe    (strobe)
  );

  mdio_mgmt_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cmdIn   (mdio_cmd_t'(regWdata[CMD_W-1:0])),
    .mdioIn  (mdioIn),
    .cmdQ    (cmdQ),
    .stSeen  (stSeen),
    .isRead  (isRead),
    .rdData  (rdData),
    .mdioOut (mdioOut),
    .mdioOe  (mdioOe)
  );

  always_comb begin
    if (cmdHit)       regRdData = {busy, 2'b00, stSeen, cmdQ};
    else if (statHit) regRdData = {cfgThr, cfgEdge, cfgLat, 3'b000, idle, rdData};
    else              regRdData = '0;
  end
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  mdio_mgmt_master uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int edgeCnt = 0;
  bit monOn = 0, busDrive = 0, finished = 0;

  // behavioural model state
  int curThr = 0, curEdge = 0, curLat = 0;
  bit haveFrame = 0, fRead = 0, fEdge = 0;
  int fW = 0, fH = 1, fEff = 0, fDone = 0;
  logic [63:0] fFrame = '0;
  logic [15:0] fResp = '0;
  logic [31:0] storedCtrl = '0;
  logic [15:0] lastRead = '0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, exp, edgeCnt);
    end
  endtask

  function automatic bit busyAt(int e);
    if (!haveFrame) return 0;
    return (e - fW) < 128 * fH;
  endfunction

  function automatic bit idleAt(int e);
    if (!haveFrame) return 1;
    return (e - fW) >= fDone;
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    int c, h, idx;
    bit bE, mE, oE, outE;
    if (monOn) begin
      bE = busyAt(edgeCnt);
      c = edgeCnt - fW;
      h = bE ? c / fH : 0;
      mE = bE && (h % 2 == 1);
      if (fEdge) idx = ((h + 1) / 2 > 63) ? 63 : (h + 1) / 2;
      else       idx = h / 2;
      oE = bE && !(fRead && idx >= 46);
      outE = oE ? fFrame[63 - idx] : 1'b1;
      chk(mdc === mE, "R3 mdc", 32'(mdc), 32'(mE));
      chk(mdioOe === oE, "R6 oe", 32'(mdioOe), 32'(oE));
      chk(mdioOut === outE, "R4/R5 mdioOut", 32'(mdioOut), 32'(outE));
      if (regAddr == 3'd0)
        chk(regRdData[31] === bE, "R2 busy", 32'(regRdData[31]), 32'(bE));
      else if (regAddr == 3'd4)
        chk(regRdData[16] === idleAt(edgeCnt), "R8 idle", 32'(regRdData[16]), 32'(idleAt(edgeCnt)));
    end
  end

  // address alternation while the bus is free
  always @(posedge clk) begin
    #2;
    if (!busDrive) regAddr = regAddr ^ 3'd4;
  end

  // PHY reply during read data bits
  always @(posedge clk) begin
    int c1, g, j;
    #2;
    mdioIn = 1'b1;
    if (haveFrame && fRead) begin
      c1 = edgeCnt + 1 - fW;
      g = c1 / fH - 1;
      if (g >= 0 && c1 < 130 * fH) begin
        j = g / 2 - 48;
        if (j >= 0 && j < 16) mdioIn = fResp[15 - j];
      end
    end
  end

  task automatic issue(input logic [31:0] v, input logic [15:0] resp);
    int e;
    @(posedge clk);
    #1 busDrive = 1;
    #2 regAddr = 3'd0; regWdata = v; regWrEn = 1'b1;
    @(posedge clk);
    #1;
    e = edgeCnt;
    if (v[31] && v[28] && idleAt(e - 1)) begin
      haveFrame = 1;
      fW = e;
      fH = (curThr == 0) ? 1 : curThr;
      fEff = (curLat < 2 * fH - 2) ? curLat : 2 * fH - 2;
      fEdge = curEdge[0];
      fRead = (v[27:26] == 2'b10);
      fResp = resp;
      fFrame = {32'hFFFF_FFFF, 2'b01, v[27:16], (fRead ? 2'b11 : 2'b10), (fRead ? 16'h0000 : v[15:0])};
      if (fRead) begin
        fDone = (127 * fH + 1 + fEff > 128 * fH) ? 127 * fH + 1 + fEff : 128 * fH;
        lastRead = resp;
      end else begin
        fDone = 128 * fH;
      end
      storedCtrl = {4'b0001, v[27:0]};
    end
    regWrEn = 1'b0;
    busDrive = 0;
  endtask

  task automatic setCfg(input int thr, input int edg, input int lat);
    @(posedge clk);
    #1 busDrive = 1;
    #2 regAddr = 3'd4; regWdata = {8'(thr), 1'(edg), 3'(lat), 20'h0}; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0; busDrive = 0;
    curThr = thr; curEdge = edg; curLat = lat;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] v);
    @(posedge clk);
    #1 busDrive = 1;
    #2 regAddr = a;
    @(negedge clk);
    v = regRdData;
    busDrive = 0;
  endtask

  task automatic waitDone();
    repeat (fDone + 3) @(posedge clk);
  endtask

  function automatic logic [31:0] statExp();
    return {8'(curThr), 1'(curEdge), 3'(curLat), 3'b000, 1'b1, lastRead};
  endfunction

  initial begin
    logic [31:0] v;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    monOn = 1;

    // R1 reset state
    readReg(3'd0, v); chk(v === 32'h0, "R1 command word", v, 32'h0);
    readReg(3'd4, v); chk(v === 32'h0001_0000, "R1 status word", v, 32'h0001_0000);
    chk(mdc === 1'b0, "R1 mdc", 32'(mdc), 0);
    chk(mdioOe === 1'b0, "R1 oe", 32'(mdioOe), 0);

    // write frame, H=2, falling-edge drive
    setCfg(2, 0, 0);
    readReg(3'd4, v); chk(v === statExp(), "R11 status readback", v, statExp());
    issue(32'h962A_A55A, 16'h0);
    readReg(3'd0, v); chk(v === (storedCtrl | 32'h8000_0000), "R11 command readback busy", v, storedCtrl | 32'h8000_0000);
    repeat (20) @(posedge clk);
    issue(32'h9BFF_1234, 16'hFFFF);  // R9 mid-frame write
    readReg(3'd0, v); chk(v === (storedCtrl | 32'h8000_0000), "R9 fields unchanged", v, storedCtrl | 32'h8000_0000);
    waitDone();
    readReg(3'd0, v); chk(v === storedCtrl, "R2 busy cleared", v, storedCtrl);

    // read frame, H=3, early drive edge, delay 2
    setCfg(3, 1, 2);
    issue(32'h987F_0000, 16'hC3A5);
    waitDone();
    readReg(3'd4, v); chk(v === statExp(), "R7 read data C3A5", v, statExp());

    // read frame, threshold 0 (H=1), delay 5 clamped to 0
    setCfg(0, 0, 5);
    issue(32'h9BC1_0000, 16'h5A0F);
    waitDone();
    readReg(3'd4, v); chk(v === statExp(), "R7 read data 5A0F clamp", v, statExp());

    // R10 rejected launches
    issue(32'h8A00_1111, 16'h0);
    issue(32'h1400_FFFF, 16'h0);
    repeat (6) @(posedge clk);
    readReg(3'd0, v); chk(v === storedCtrl, "R10 no launch", v, storedCtrl);

    // write frame, H=1, early drive edge
    setCfg(1, 1, 7);
    issue(32'h9410_8001, 16'h0);
    waitDone();
    readReg(3'd0, v); chk(v === storedCtrl, "R5 write done", v, storedCtrl);

    // read frame, H=2, delay 7 clamped to 2
    setCfg(2, 0, 7);
    issue(32'h9822_0000, 16'h0FF0);
    waitDone();
    readReg(3'd4, v); chk(v === statExp(), "R7 read data 0FF0 clamp", v, statExp());

    repeat (4) @(posedge clk);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule